// File: doc/BRIEF.md
# UART Receive Idle-Line Detector

This block watches the receive line of a UART and raises a sticky idle flag once the line has stayed high for a programmed stretch of time after a character. The time is counted in bit periods, using a one-cycle tick from an external baud generator. The character receiver is a separate block. It reports only two one-cycle strobes to this detector: one when a valid start bit is accepted and one when a stop bit completes.

The default rule counts whole character times. The length of one character follows from the frame format. A 3-bit code selects a power-of-two number of characters, from 1 up to 128. A type select chooses the start point of the count: either the accepted start bit or the completed stop bit. When the extended bit count is nonzero, it replaces that rule with a raw number of bit times measured from the last stop bit. Software clears the flag by writing one to it. An enable gates the flag onto the interrupt request.

Top module: `uart_idle_detect`

## Requirements
- R1: One character time is 1 + (7 if `cfg_data7` is 1, else 8) + (1 if `cfg_par_en` is 1) + (2 if `cfg_stop2` is 1, else 1) bit ticks. With `cfg_ext_bits` equal to 0, the idle threshold is that character time multiplied by 2^`cfg_idle_code` (code 0 gives 1 character, code 7 gives 128).
- R2: With `cfg_idle_after_stop` = 0 and the extended count at 0, a `start_seen` strobe arms the detector and restarts the count from zero. `stop_seen` has no effect in this mode.
- R3: With `cfg_idle_after_stop` = 1, a `start_seen` strobe disarms the detector and zeroes the count. A `stop_seen` strobe arms it and restarts the count from zero.
- R4: A nonzero `cfg_ext_bits` makes the threshold equal to that value. The stop-bit start point of R3 then applies, whatever `cfg_idle_after_stop` and `cfg_idle_code` hold.
- R5: While the detector is armed and `rx_en` is 1, each `bit_tick` that samples `rxd` high adds one to the count. On the tick that brings the count to the threshold, `idle_flag` goes to 1 on the following clock edge.
- R6: A `bit_tick` that samples `rxd` low zeroes the count. The detector stays armed.
- R7: Setting the flag disarms the detector. No further set happens until the next arming strobe, even if the line stays high.
- R8: `idle_flag` stays at 1 until `idle_clr` is 1 at a clock edge. If a set and a clear fall on the same edge, the flag stays at 1.
- R9: While `rx_en` is 0, ticks and strobes are ignored. The count and the armed state hold their values.
- R10: `idle_irq` equals `idle_flag` AND `idle_irq_en`.
- R11: After reset, `idle_flag` and `idle_irq` are 0 and the detector is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable; counting is suspended while low |
| rxd | input | 1 | Serial receive line, idle high |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| start_seen | input | 1 | Strobe: the receiver accepted a valid start bit |
| stop_seen | input | 1 | Strobe: the receiver completed a stop bit |
| cfg_data7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| cfg_idle_after_stop | input | 1 | Count start point: 0 = after start bit, 1 = after stop bit |
| cfg_idle_code | input | 3 | Idle character count is 2^code |
| cfg_ext_bits | input | EXT_W | Extended idle threshold in bit times; 0 disables it |
| idle_clr | input | 1 | Write-one-to-clear for the idle flag |
| idle_irq_en | input | 1 | Interrupt enable |
| idle_flag | output | 1 | Sticky idle flag |
| idle_irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the flag stays set until it is cleared, and that a clear without a set drops it. They also check that the count holds while the receiver is disabled, that a low sample zeroes it, and that a set always leaves the detector disarmed. Only the bench scenarios show the exact tick on which the flag rises for each frame format, idle code and extended value. The same holds for the difference between the start-bit and stop-bit start points, and for set-over-clear priority with a real count.

// File: rtl/uart_idle_pkg.sv
// Shared sizing and helper functions for the idle-line detector.
// Assumes frame formats of 7 or 8 data bits, optional parity, 1 or 2 stops.
package uart_idle_pkg;

    // Widest character time is 12 bits, times 128 characters = 1536.
    localparam int CHAR_THR_W = 11;

    // Number of bit ticks in one character for the given frame format.
    function automatic logic [3:0] char_ticks(input logic data7,
                                              input logic par_en,
                                              input logic stop2);
        logic [3:0] n;
        n = 4'd1;                              // start bit
        n = n + (data7 ? 4'd7 : 4'd8);         // data bits
        n = n + {3'd0, par_en};                // optional parity
        n = n + (stop2 ? 4'd2 : 4'd1);         // stop bits
        return n;
    endfunction

endpackage

// File: rtl/uart_idle_thresh.sv
// Idle threshold selector: extended bit count when nonzero, otherwise the
// character time scaled by 2^code. Also reports which start point applies.
// Purely combinational; assumes configuration is quasi-static.
module uart_idle_thresh
    import uart_idle_pkg::*;
#(
    parameter int EXT_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             cfg_data7,
    input  logic             cfg_par_en,
    input  logic             cfg_stop2,
    input  logic             cfg_idle_after_stop,
    input  logic [2:0]       cfg_idle_code,
    input  logic [EXT_W-1:0] cfg_ext_bits,
    output logic [CNT_W-1:0] thr,
    output logic             use_stop
);

    logic             ext_mode;
    logic [CNT_W-1:0] char_thr;

    // Select threshold and start point from the mode inputs (R1, R4).
    always_comb begin
        ext_mode = (cfg_ext_bits != '0);
        char_thr = CNT_W'(char_ticks(cfg_data7, cfg_par_en, cfg_stop2)) << cfg_idle_code;
        thr      = ext_mode ? CNT_W'(cfg_ext_bits) : char_thr;
        use_stop = ext_mode | cfg_idle_after_stop;
    end

endmodule

// File: rtl/uart_idle_counter.sv
// Idle bit counter with arm state. Arms on the selected strobe, counts high
// samples at bit ticks, zeroes on a low sample, and emits a one-cycle set
// pulse when the threshold is reached. Assumes threshold is at least 1.
module uart_idle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rxd,
    input  logic             bit_tick,
    input  logic             start_seen,
    input  logic             stop_seen,
    input  logic             use_stop,
    input  logic [CNT_W-1:0] thr,
    output logic             set_pulse
);

    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             arm_evt;
    logic             disarm_evt;
    logic [CNT_W:0]   cnt_inc;
    logic             count_ok;

    // Decode arming events and the threshold hit (R2, R3, R5).
    always_comb begin
        arm_evt    = use_stop ? stop_seen : start_seen;
        disarm_evt = use_stop & start_seen;
        cnt_inc    = {1'b0, cnt} + 1'b1;
        count_ok   = rx_en & armed & bit_tick & rxd & ~arm_evt & ~disarm_evt;
        set_pulse  = count_ok & (cnt_inc >= {1'b0, thr});
    end

    // Count and arm-state register; frozen while the receiver is disabled (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (rx_en) begin
            if (arm_evt) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (disarm_evt) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else if (armed && bit_tick) begin
                if (!rxd) begin
                    cnt <= '0;
                end else if (set_pulse) begin
                    cnt   <= '0;
                    armed <= 1'b0;
                end else begin
                    cnt <= cnt_inc[CNT_W-1:0];
                end
            end
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> ($stable(cnt) && $stable(armed)));                        // R9
    AST_LOW_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && bit_tick && !rxd) |=> (cnt == '0));                          // R6
    AST_SET_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !armed);                                                // R7

endmodule

// File: rtl/uart_idle_flag.sv
// Sticky idle flag with write-one-to-clear and interrupt gating.
// A set on the same edge as a clear wins.
module uart_idle_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic idle_clr,
    input  logic idle_irq_en,
    output logic idle_flag,
    output logic idle_irq
);

    // Sticky flag register: set has priority over clear (R8, R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_flag <= 1'b0;
        end else if (set_pulse) begin
            idle_flag <= 1'b1;
        end else if (idle_clr) begin
            idle_flag <= 1'b0;
        end
    end

    // Interrupt request gated by the enable (R10).
    assign idle_irq = idle_flag & idle_irq_en;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !idle_clr) |=> idle_flag);                              // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_clr && !set_pulse) |=> !idle_flag);                             // R8
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> idle_flag);                                             // R5

endmodule

// File: rtl/uart_idle_detect.sv
// UART receive idle-line detector top. Combines threshold selection, the idle
// counter and the sticky flag. Character reception happens elsewhere and is
// seen only through the start and stop strobes.
module uart_idle_detect
    import uart_idle_pkg::*;
#(
    parameter int EXT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rxd,
    input  logic             bit_tick,
    input  logic             start_seen,
    input  logic             stop_seen,
    input  logic             cfg_data7,
    input  logic             cfg_par_en,
    input  logic             cfg_stop2,
    input  logic             cfg_idle_after_stop,
    input  logic [2:0]       cfg_idle_code,
    input  logic [EXT_W-1:0] cfg_ext_bits,
    input  logic             idle_clr,
    input  logic             idle_irq_en,
    output logic             idle_flag,
    output logic             idle_irq
);

    localparam int CNT_W = (EXT_W > CHAR_THR_W) ? EXT_W : CHAR_THR_W;

    logic [CNT_W-1:0] thr;
    logic             use_stop;
    logic             set_pulse;

    uart_idle_thresh #(.EXT_W(EXT_W), .CNT_W(CNT_W)) u_thr (
        .cfg_data7           (cfg_data7),
        .cfg_par_en          (cfg_par_en),
        .cfg_stop2           (cfg_stop2),
        .cfg_idle_after_stop (cfg_idle_after_stop),
        .cfg_idle_code       (cfg_idle_code),
        .cfg_ext_bits        (cfg_ext_bits),
        .thr                 (thr),
        .use_stop            (use_stop)
    );

    uart_idle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .rxd        (rxd),
        .bit_tick   (bit_tick),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .use_stop   (use_stop),
        .thr        (thr),
        .set_pulse  (set_pulse)
    );

    uart_idle_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_pulse   (set_pulse),
        .idle_clr    (idle_clr),
        .idle_irq_en (idle_irq_en),
        .idle_flag   (idle_flag),
        .idle_irq    (idle_irq)
    );

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_irq_en |-> !idle_irq);                                         // R10

endmodule

// File: tb/sim_uart_idle_detect.sv
`timescale 1ns/1ps
// Directed bench for the idle-line detector: one task per scenario.
module sim_uart_idle_detect;

    localparam int EXT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_en = 1'b0;
    logic             rxd = 1'b1;
    logic             bit_tick = 1'b0;
    logic             start_seen = 1'b0;
    logic             stop_seen = 1'b0;
    logic             cfg_data7 = 1'b0;
    logic             cfg_par_en = 1'b0;
    logic             cfg_stop2 = 1'b0;
    logic             cfg_idle_after_stop = 1'b0;
    logic [2:0]       cfg_idle_code = 3'd0;
    logic [EXT_W-1:0] cfg_ext_bits = '0;
    logic             idle_clr = 1'b0;
    logic             idle_irq_en = 1'b0;
    logic             idle_flag;
    logic             idle_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_idle_detect #(.EXT_W(EXT_W)) u0 (.*);

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            rxd      = v;
            @(negedge clk);
            bit_tick = 1'b0;
            rxd      = 1'b1;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); idle_clr = 1'b1;
        @(negedge clk); idle_clr = 1'b0;
    endtask

    task automatic set_fmt(input logic d7, input logic par, input logic s2,
                           input logic after_stop, input logic [2:0] code,
                           input logic [EXT_W-1:0] ext);
        @(negedge clk);
        cfg_data7 = d7; cfg_par_en = par; cfg_stop2 = s2;
        cfg_idle_after_stop = after_stop; cfg_idle_code = code; cfg_ext_bits = ext;
    endtask

    // R11: reset state
    task automatic t_reset();
        @(negedge clk);
        check("R11 flag after reset", idle_flag, 1'b0);
        check("R11 irq after reset", idle_irq, 1'b0);
        ticks(30, 1'b1);
        check("R11 disarmed after reset", idle_flag, 1'b0);
    endtask

    // R1 R2 R5: 8N1, code 0 -> 10 ticks from the start bit
    task automatic t_basic();
        set_fmt(0, 0, 0, 0, 3'd0, '0);
        pulse_start();
        ticks(9, 1'b1);
        check("R5 one tick short (8N1)", idle_flag, 1'b0);
        ticks(1, 1'b1);
        check("R1 flag at 10 ticks (8N1)", idle_flag, 1'b1);
    endtask

    // R8 R7: clear works, no re-set without a new character
    task automatic t_clear_rearm();
        clear_flag();
        check("R8 flag cleared", idle_flag, 1'b0);
        ticks(25, 1'b1);
        check("R7 no set without new char", idle_flag, 1'b0);
        pulse_stop();
        ticks(15, 1'b1);
        check("R2 stop strobe ignored in start mode", idle_flag, 1'b0);
    endtask

    // R6: low sample restarts the count
    task automatic t_low();
        pulse_start();
        ticks(6, 1'b1);
        ticks(1, 1'b0);
        ticks(9, 1'b1);
        check("R6 low sample restarted count", idle_flag, 1'b0);
        ticks(1, 1'b1);
        check("R6 flag after full run post low", idle_flag, 1'b1);
        clear_flag();
    endtask

    // R9: counting suspended while disabled
    task automatic t_suspend();
        pulse_start();
        ticks(5, 1'b1);
        @(negedge clk); rx_en = 1'b0;
        ticks(10, 1'b1);
        check("R9 no set while disabled", idle_flag, 1'b0);
        @(negedge clk); rx_en = 1'b1;
        ticks(4, 1'b1);
        check("R9 count held, one short", idle_flag, 1'b0);
        ticks(1, 1'b1);
        check("R9 count resumed to threshold", idle_flag, 1'b1);
        clear_flag();
    endtask

    // R3 R1: stop-based, 7 data + parity + 2 stop = 11, code 2 -> 44
    task automatic t_stop_mode();
        set_fmt(1, 1, 1, 1, 3'd2, '0);
        pulse_start();
        ticks(50, 1'b1);
        check("R3 start strobe disarms in stop mode", idle_flag, 1'b0);
        pulse_stop();
        ticks(43, 1'b1);
        check("R1 one short of 44", idle_flag, 1'b0);
        ticks(1, 1'b1);
        check("R3 flag at 44 after stop", idle_flag, 1'b1);
        clear_flag();
    endtask

    // R1: code 7 with 8N1 -> 1280 ticks
    task automatic t_code7();
        set_fmt(0, 0, 0, 0, 3'd7, '0);
        pulse_start();
        ticks(1279, 1'b1);
        check("R1 code 7 one short", idle_flag, 1'b0);
        ticks(1, 1'b1);
        check("R1 code 7 at 1280", idle_flag, 1'b1);
        clear_flag();
    endtask

    // R4: extended count 5 overrides type and code
    task automatic t_ext();
        set_fmt(0, 0, 0, 0, 3'd3, 16'd5);
        pulse_start();
        ticks(20, 1'b1);
        check("R4 extended ignores start strobe", idle_flag, 1'b0);
        pulse_stop();
        ticks(4, 1'b1);
        check("R4 extended one short", idle_flag, 1'b0);
        ticks(1, 1'b1);
        check("R4 extended at 5 ticks", idle_flag, 1'b1);
    endtask

    // R10: interrupt gating
    task automatic t_irq();
        check("R10 irq masked", idle_irq, 1'b0);
        @(negedge clk); idle_irq_en = 1'b1;
        #1;
        check("R10 irq enabled", idle_irq, 1'b1);
        @(negedge clk); idle_irq_en = 1'b0;
        #1;
        check("R10 irq masked again", idle_irq, 1'b0);
        clear_flag();
    endtask

    // R8: set and clear on the same edge keeps the flag
    task automatic t_set_vs_clear();
        set_fmt(0, 0, 0, 0, 3'd0, '0);
        pulse_start();
        ticks(10, 1'b1);
        check("R8 flag set before collision", idle_flag, 1'b1);
        pulse_start();
        ticks(9, 1'b1);
        @(negedge clk);
        bit_tick = 1'b1; rxd = 1'b1; idle_clr = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; idle_clr = 1'b0;
        check("R8 set wins over clear", idle_flag, 1'b1);
        clear_flag();
        check("R8 plain clear after collision", idle_flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rx_en = 1'b1;
        t_reset();
        t_basic();
        t_clear_rearm();
        t_low();
        t_suspend();
        t_stop_mode();
        t_code7();
        t_ext();
        t_irq();
        t_set_vs_clear();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule